// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a 32-bit software interrupt request word, written by one of up to eight processors, into pending bits. It keeps one pending bit for each combination of interrupt ID, source processor and destination processor. The request word names the interrupt ID, a list of destination processors, and a filter that picks how that list is used. The requester's own processor number arrives on a separate input with each write. Destinations whose CPU interface is disabled are skipped.

A downstream priority selector reads the flattened pending flags. For each destination and ID, a flag is the OR of that bit over all sources. A selection port (destination, ID) gives an acknowledge result: the highest-numbered source that holds a pending request for that pair, packed with the ID. Pulsing the acknowledge input clears exactly that source's bit. If a new write sets the same bit in the same cycle, the write wins.

Top module: `sgi_dispatch`

## Requirements
- R1: After a synchronous active-low reset, every pending bit is zero and the acknowledge result shows the "none" code.
- R2: Request word bits [3:0] give the interrupt ID and bits [23:16] give the destination list, one bit per processor. With filter bits [25:24] = 0, exactly the listed processors become pending. All other bits of the word are ignored.
- R3: Filter value 1 targets every processor except the requester given on `wr_src`.
- R4: Filter value 2 targets only the requester.
- R5: Filter value 3 sets no pending bits.
- R6: A destination whose `cpu_if_en` bit is low never gains a pending bit from a write.
- R7: Pending state is kept separately per source. For the selected (destination, ID) pair, the result names the highest-numbered pending source. Each acknowledge clears only that source's bit, so the next lower source is then reported.
- R8: `ack_result[12:10]` holds the source number and `ack_result[9:0]` holds the interrupt ID. When nothing is pending for the selected pair, the result is source 0 with ID 1023.
- R9: When a write sets the same bit that an acknowledge clears in the same cycle, the bit stays set.
- R10: `pend_out[d*NUM_ID+i]` is the OR over sources of the bit for destination d and ID i. An acknowledge with nothing pending, or a request word on the port while `wr_en` is low, changes no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Request word write strobe |
| wr_src | input | 3 | Processor number of the writer |
| wr_data | input | 32 | Request word |
| cpu_if_en | input | 8 | CPU interface enable, one bit per destination |
| sel_dst | input | 3 | Destination selected for acknowledge |
| sel_id | input | 4 | Interrupt ID selected for acknowledge |
| ack | input | 1 | Acknowledge: clear the reported source's bit |
| ack_result | output | 13 | Source [12:10] and ID [9:0] for the selected pair |
| pend_out | output | 128 | Pending flags, index d*16+i |

## Verification
A vector table drives each filter value from several requesters. Each vector sets junk in the ignored word bits and uses partial enable masks. This separates list use from "all but self" and "self only", and shows that the reserved filter and disabled interfaces add nothing. The check also counts every set bit, so a wrong ID or a stray bit shows up. Directed sequences stack two sources on one pair to expose source ordering and single-bit clearing. A further sequence collides a write with an acknowledge on the same bit. Others issue acknowledges and strobe-less words that must leave unrelated state alone.

// File: rtl/sgi_pkg.sv
// Shared constants and types for the software interrupt dispatcher.
// Assumes a 32-bit request word and a 13-bit acknowledge result.
package sgi_pkg;
    localparam int REQ_ID_LSB   = 0;
    localparam int REQ_LIST_LSB = 16;
    localparam int REQ_FILT_LSB = 24;
    localparam int RES_SRC_LSB  = 10;
    localparam int RES_ID_W     = 10;
    localparam logic [RES_ID_W-1:0] RES_NONE_ID = 10'd1023;

    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_RSVD   = 2'd3
    } filt_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Computes the destination mask of one request from its list, filter and
// requester, gated by the CPU interface enables. Purely combinational.
module sgi_target_decode #(
    parameter int NUM_CPU = 8,
    localparam int SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [NUM_CPU-1:0] list,
    input  sgi_pkg::filt_e     filt,
    input  logic [SRC_W-1:0]   src,
    input  logic [NUM_CPU-1:0] if_en,
    output logic [NUM_CPU-1:0] tgt
);
    logic [NUM_CPU-1:0] self_mask;

    // One-hot mask of the requester.
    always_comb begin
        self_mask = '0;
        self_mask[src] = 1'b1;
    end

    // Apply the filter, then drop disabled destinations.
    always_comb begin
        unique case (filt)
            sgi_pkg::FILT_LIST:   tgt = list;
            sgi_pkg::FILT_OTHERS: tgt = ~self_mask;
            sgi_pkg::FILT_SELF:   tgt = self_mask;
            default:              tgt = '0;
        endcase
        tgt = tgt & if_en;
    end
endmodule

// File: rtl/sgi_pend_row.sv
// Pending bits of one (ID, source) pair, one bit per destination.
// The set mask has precedence over the clear mask.
module sgi_pend_row #(
    parameter int NUM_CPU = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] set_mask,
    input  logic [NUM_CPU-1:0] clr_mask,
    output logic [NUM_CPU-1:0] q
);
    // Hold, clear or set each destination bit.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= set_mask | (q & ~clr_mask);
    end
endmodule

// File: rtl/sgi_src_pick.sv
// Finds the highest-numbered source whose bit is set in a column.
// Assumes the column is indexed by source number.
module sgi_src_pick #(
    parameter int NUM_CPU = 8,
    localparam int SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [NUM_CPU-1:0] col,
    output logic               hit,
    output logic [SRC_W-1:0]   src
);
    // Scan upward so the last set bit wins.
    always_comb begin
        src = '0;
        for (int s = 0; s < NUM_CPU; s++)
            if (col[s]) src = SRC_W'(s);
        hit = |col;
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Software interrupt dispatcher top. Holds an ID x source x destination
// pending matrix, sets it from request words and clears one bit per
// acknowledge. Assumes NUM_CPU <= 8 and NUM_ID <= 16.
module sgi_dispatch #(
    parameter int NUM_CPU = 8,
    parameter int NUM_ID  = 16,
    localparam int SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W   = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SRC_W-1:0]          wr_src,
    input  logic [31:0]               wr_data,
    input  logic [NUM_CPU-1:0]        cpu_if_en,
    input  logic [SRC_W-1:0]          sel_dst,
    input  logic [ID_W-1:0]           sel_id,
    input  logic                      ack,
    output logic [12:0]               ack_result,
    output logic [NUM_CPU*NUM_ID-1:0] pend_out
);
    import sgi_pkg::*;

    logic [NUM_CPU-1:0] tgt;
    logic [3:0]         req_id;
    logic [NUM_ID-1:0][NUM_CPU-1:0][NUM_CPU-1:0] pend_q;
    logic [NUM_CPU-1:0] col;
    logic               hit;
    logic [SRC_W-1:0]   pick_src;
    logic [NUM_CPU-1:0] dst_onehot;
    logic               unused_bits;

    assign req_id      = wr_data[REQ_ID_LSB +: 4];
    assign unused_bits = ^{wr_data[31:26], wr_data[15:4]};

    sgi_target_decode #(.NUM_CPU(NUM_CPU)) u_decode (
        .list  (wr_data[REQ_LIST_LSB +: NUM_CPU]),
        .filt  (filt_e'(wr_data[REQ_FILT_LSB +: 2])),
        .src   (wr_src),
        .if_en (cpu_if_en),
        .tgt   (tgt)
    );

    // One-hot of the selected destination, used as the clear mask.
    always_comb begin
        dst_onehot = '0;
        dst_onehot[sel_dst] = 1'b1;
    end

    for (genvar i = 0; i < NUM_ID; i++) begin : g_id
        for (genvar s = 0; s < NUM_CPU; s++) begin : g_src
            logic [NUM_CPU-1:0] set_m;
            logic [NUM_CPU-1:0] clr_m;
            // Set from a matching write; clear the reported source on ack.
            always_comb begin
                set_m = (wr_en && req_id == 4'(i) && wr_src == SRC_W'(s)) ? tgt : '0;
                clr_m = (ack && hit && sel_id == ID_W'(i) && pick_src == SRC_W'(s))
                        ? dst_onehot : '0;
            end
            sgi_pend_row #(.NUM_CPU(NUM_CPU)) u_row (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_mask (set_m),
                .clr_mask (clr_m),
                .q        (pend_q[i][s])
            );
        end
    end

    // Gather the per-source column of the selected (ID, destination).
    always_comb begin
        for (int s = 0; s < NUM_CPU; s++)
            col[s] = pend_q[sel_id][s][sel_dst];
    end

    sgi_src_pick #(.NUM_CPU(NUM_CPU)) u_pick (
        .col (col),
        .hit (hit),
        .src (pick_src)
    );

    // Pack source and ID, or the none code when nothing is pending.
    always_comb begin
        if (hit) ack_result = {3'(pick_src), RES_ID_W'(sel_id)};
        else     ack_result = {3'b000, RES_NONE_ID};
    end

    // OR each destination/ID bit over all sources.
    always_comb begin
        pend_out = '0;
        for (int d = 0; d < NUM_CPU; d++)
            for (int i = 0; i < NUM_ID; i++)
                for (int s = 0; s < NUM_CPU; s++)
                    pend_out[d*NUM_ID+i] = pend_out[d*NUM_ID+i] | pend_q[i][s][d];
    end
endmodule

// File: rtl/sgi_dispatch_chk.sv
// Assertion checker for sgi_dispatch, bound to every instance below.
// Looks only at the top-level ports.
module sgi_dispatch_chk #(
    parameter int NUM_CPU = 8,
    parameter int NUM_ID  = 16,
    localparam int SRC_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ID_W   = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [SRC_W-1:0]          wr_src,
    input logic [31:0]               wr_data,
    input logic [NUM_CPU-1:0]        cpu_if_en,
    input logic [SRC_W-1:0]          sel_dst,
    input logic [ID_W-1:0]           sel_id,
    input logic                      ack,
    input logic [12:0]               ack_result,
    input logic [NUM_CPU*NUM_ID-1:0] pend_out
);
    logic rst_q;

    // Remember the previous reset level.
    always_ff @(posedge clk) rst_q <= rst_n;

    // R1: the first cycle out of reset shows no pending bits.
    always @(posedge clk)
        if (rst_n && !rst_q)
            p_reset_clear_r1: assert (pend_out == '0);

    // R5: the reserved filter alone leaves the state unchanged.
    p_rsvd_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd3 && !ack) |=> $stable(pend_out));

    // R4: a self-only request to an enabled requester sets its own bit.
    p_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd2 && cpu_if_en[wr_src] && 32'(wr_data[3:0]) < NUM_ID)
        |=> pend_out[32'($past(wr_src))*NUM_ID + 32'($past(wr_data[3:0]))]);

    // R8: nothing pending for the pair gives the none code.
    p_none_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_out[32'(sel_dst)*NUM_ID + 32'(sel_id)] |-> ack_result == 13'h03FF);

    // R7: an acknowledge with no write moves the result on.
    p_ack_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_en && pend_out[32'(sel_dst)*NUM_ID + 32'(sel_id)])
        |=> (!($stable(sel_dst) && $stable(sel_id)) || ack_result != $past(ack_result)));

    for (genvar d = 0; d < NUM_CPU; d++) begin : g_dst
        // R6: no bit of a destination rises unless a write targets an enabled one.
        p_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && cpu_if_en[d])
            |=> (pend_out[d*NUM_ID +: NUM_ID] & ~$past(pend_out[d*NUM_ID +: NUM_ID])) == '0);

        // R9: a listed, enabled destination is pending next cycle, ack or not.
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[25:24] == 2'd0 && wr_data[16+d] && cpu_if_en[d]
             && 32'(wr_data[3:0]) < NUM_ID)
            |=> pend_out[d*NUM_ID + 32'($past(wr_data[3:0]))]);
    end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU), .NUM_ID(NUM_ID)) u_chk (.*);

// File: tb/sgi_dispatch_bench.sv
// Self-checking bench for sgi_dispatch.
module sgi_dispatch_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_src = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   cpu_if_en = 8'hFF;
    logic [2:0]   sel_dst = '0;
    logic [3:0]   sel_id = '0;
    logic         ack = 1'b0;
    logic [12:0]  ack_result;
    logic [127:0] pend_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sgi_dispatch u_sgi_dispatch (.*);

    // {src[2:0], word[31:0], enables[7:0], expected destination mask[7:0]}
    localparam logic [50:0] VEC [0:7] = '{
        {3'd0, 32'hFC05FFF3, 8'hFF, 8'h05},  // R2 list use, junk bits ignored
        {3'd2, 32'hFCF0FFFF, 8'h3F, 8'h30},  // R6 partial enables
        {3'd1, 32'hFD00FFF7, 8'hFF, 8'hFD},  // R3 all but requester
        {3'd4, 32'hFEAAFFF0, 8'hFF, 8'h10},  // R4 self only
        {3'd4, 32'hFEAAFFF0, 8'hEF, 8'h00},  // R6 self disabled
        {3'd3, 32'hFFFFFFF9, 8'hFF, 8'h00},  // R5 reserved filter
        {3'd7, 32'hFD00FFF1, 8'h0F, 8'h0F},  // R3 with R6
        {3'd0, 32'hFD00FFF2, 8'hFF, 8'hFE}   // R3 requester 0
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [2:0] s, input logic [31:0] w, input logic [7:0] en);
        @(negedge clk);
        wr_en = 1'b1; wr_src = s; wr_data = w; cpu_if_en = en;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    function automatic logic [7:0] dst_mask(input logic [3:0] id);
        for (int d = 0; d < 8; d++) dst_mask[d] = pend_out[d*16 + id];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        chk(32'(pend_out != '0), 0, "R1 pending after reset");
        chk(32'(ack_result), 32'h3FF, "R1 R8 result after reset");

        for (int v = 0; v < 8; v++) begin
            do_reset();
            do_write(VEC[v][50:48], VEC[v][47:16], VEC[v][15:8]);
            chk(32'(dst_mask(VEC[v][19:16])), 32'(VEC[v][7:0]), $sformatf("R2-table vec%0d mask", v));
            chk(32'($countones(pend_out)), 32'($countones(VEC[v][7:0])), $sformatf("R10 table vec%0d count", v));
        end

        // R7: two sources on one pair, highest reported, cleared one at a time.
        do_reset();
        sel_dst = 3'd2; sel_id = 4'd5;
        do_write(3'd1, 32'h0004_0005, 8'hFF);
        do_write(3'd6, 32'h0004_0005, 8'hFF);
        chk(32'(ack_result), 32'h1805, "R7 R8 highest source");
        do_ack();
        chk(32'(ack_result), 32'h0405, "R7 lower source after ack");
        chk(32'(pend_out[2*16+5]), 1, "R10 flag still set");
        do_ack();
        chk(32'(ack_result), 32'h3FF, "R7 none after second ack");
        chk(32'(pend_out[2*16+5]), 0, "R10 flag cleared");

        // R9: write and acknowledge of the same bit together.
        do_reset();
        sel_dst = 3'd0; sel_id = 4'd8;
        do_write(3'd3, 32'h0001_0008, 8'hFF);
        chk(32'(ack_result), 32'h0C08, "R9 before collision");
        @(negedge clk);
        ack = 1'b1; wr_en = 1'b1; wr_src = 3'd3; wr_data = 32'h0001_0008;
        @(negedge clk);
        ack = 1'b0; wr_en = 1'b0;
        chk(32'(ack_result), 32'h0C08, "R9 set wins");
        do_ack();
        chk(32'(ack_result), 32'h3FF, "R9 cleared by lone ack");

        // R10: idle acknowledge and strobe-less word leave state alone.
        do_reset();
        do_write(3'd0, 32'h0002_0002, 8'hFF);
        sel_dst = 3'd5; sel_id = 4'd2;
        do_ack();
        chk(32'(pend_out[1*16+2]), 1, "R10 idle ack kept bit");
        @(negedge clk) wr_data = 32'h00FF_0004;
        @(negedge clk);
        chk(32'($countones(pend_out)), 1, "R10 no write without strobe");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule